// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the fast clock that feeds two banks of divided clocks, bank A and bank C. It drives one sync output. The output marks each rising edge on which both bank clocks rise together. It falls a fixed lead ahead of that shared edge and rises again exactly at it. A downstream consumer can therefore see a shared edge coming, even when the two banks run at a ratio that is not a whole number.

The block does not generate the bank clocks. It assumes they come from counters that are released from the same synchronous reset as this block, so that every bank rises at count zero. The two divide ratios arrive as small select codes. From these the block derives two values: the repeat interval of the shared edges and the lead. A counter running modulo that interval then places the low window.

Top module: `csync_gen`

## Requirements
- R1: The select `sel_a` picks the bank A divisor: code 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 12. The select `sel_c` picks the bank C divisor: code 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8. Counting fast cycles after reset release, a bank rises on every cycle whose index is a multiple of its divisor. Cycle 0 is the interval before the first edge that samples reset low.
- R2: While `rst` is high, `sync_o` is high from the first clock edge onward. In the interval right after release it is still high.
- R3: The lead is the smaller of the two divisors. `sync_o` is low for exactly that many fast cycles immediately before each rising edge on which the window period restarts. It is never low for longer than that.
- R4: For unequal divisors, the window period is the least common multiple of the two divisors. `sync_o` goes high on the shared rising edge and stays high until the next low window. Every high stretch lasts at least two fast cycles.
- R5: For equal divisors d, every bank edge is shared. The window period is then 2·d, so `sync_o` alternates between d cycles high and d cycles low. It goes high on every second shared edge.
- R6: The output pattern holds for integer-multiple ratios (2:1, 3:1, 4:1, 6:1) and for non-integer ratios (3:2, 4:3) between the two banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (prescaled) clock shared with the bank dividers |
| rst | input | 1 | Synchronous active-high reset, released together with the dividers |
| sel_a | input | 2 | Bank A divisor select |
| sel_c | input | 2 | Bank C divisor select |
| sync_o | output | 1 | Registered sync output, low ahead of each shared edge |

## Verification
The assertions check several rules on every cycle. The output is forced high under reset. A low stretch never exceeds the smaller divisor. A fall is never a single-cycle glitch, and a rise is always followed by at least one more high cycle. The bench's scenarios are the only way to show that the low window sits at the right place relative to the shared edge. They also show that the window period really is the least common multiple (or twice the divisor for equal ratios) and that each select code maps to the right divisor. Each case runs for several full window periods.

// File: rtl/csync_pkg.sv
package csync_pkg;
  localparam int SEL_W = 2;
  localparam int N_SEL = 1 << SEL_W;
  localparam int DIV_A [N_SEL] = '{4, 6, 8, 12};
  localparam int DIV_C [N_SEL] = '{2, 4, 6, 8};

  function automatic int lcm_f(int x, int y);
    int r;
    bit found;
    r = x * y;
    found = 1'b0;
    for (int k = 1; k <= 64; k++) begin
      if (!found && k <= y && ((x * k) % y) == 0) begin
        r = x * k;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic int lead_f(int x, int y);
    return (x < y) ? x : y;
  endfunction

  // equal divisors: the low/high pattern spans two shared edges
  function automatic int period_f(int x, int y);
    return (x == y) ? 2 * x : lcm_f(x, y);
  endfunction

  function automatic int max_period_f();
    int m;
    m = 1;
    for (int i = 0; i < N_SEL; i++)
      for (int j = 0; j < N_SEL; j++)
        if (period_f(DIV_A[i], DIV_C[j]) > m) m = period_f(DIV_A[i], DIV_C[j]);
    return m;
  endfunction

  localparam int MAX_PERIOD = max_period_f();
  localparam int CNT_W = $clog2(MAX_PERIOD + 1);
endpackage

// File: rtl/csync_ratio_rom.sv
module csync_ratio_rom
  import csync_pkg::*;
(
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] lead_o
);
  localparam int N_ENT = N_SEL * N_SEL;

  logic [CNT_W-1:0] per_tab  [N_ENT];
  logic [CNT_W-1:0] lead_tab [N_ENT];

  for (genvar ga = 0; ga < N_SEL; ga++) begin : g_a
    for (genvar gc = 0; gc < N_SEL; gc++) begin : g_c
      assign per_tab[ga*N_SEL+gc]  = CNT_W'(period_f(DIV_A[ga], DIV_C[gc]));
      assign lead_tab[ga*N_SEL+gc] = CNT_W'(lead_f(DIV_A[ga], DIV_C[gc]));
    end
  end

  assign period_o = per_tab[{sel_a, sel_c}];
  assign lead_o   = lead_tab[{sel_a, sel_c}];
endmodule

// File: rtl/csync_phase_cnt.sv
module csync_phase_cnt
  import csync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;

  // wraps on the last slot; a count beyond a shrunken period also wraps
  always_comb begin
    if (rst)
      cnt_nxt = '0;
    else if (cnt_q >= period - CNT_W'(1))
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/csync_window.sv
module csync_window
  import csync_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] lead,
  output logic             low
);
  assign low = (cnt >= period - lead);
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output logic             sync_o
);
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] cnt_nxt;
  logic             low;

  csync_ratio_rom u_rom (
    .sel_a    (sel_a),
    .sel_c    (sel_c),
    .period_o (period),
    .lead_o   (lead)
  );

  csync_phase_cnt u_cnt (
    .clk     (clk),
    .rst     (rst),
    .period  (period),
    .cnt_nxt (cnt_nxt)
  );

  csync_window u_win (
    .cnt    (cnt_nxt),
    .period (period),
    .lead   (lead),
    .low    (low)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_o <= 1'b1;
    else     sync_o <= ~low;
  end
endmodule

// File: rtl/csync_checker.sv
module csync_checker
  import csync_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] sel_a,
  input logic [SEL_W-1:0] sel_c,
  input logic             sync_o
);
  logic [CNT_W-1:0]   low_run;
  logic [2*SEL_W-1:0] sel_q;
  logic [CNT_W-1:0]   lead_chk;
  logic               sel_chg;

  assign lead_chk = CNT_W'(lead_f(DIV_A[sel_a], DIV_C[sel_c]));
  assign sel_chg  = ({sel_a, sel_c} != sel_q);

  always_ff @(posedge clk) begin
    sel_q <= {sel_a, sel_c};
    if (rst || sel_chg || sync_o) low_run <= '0;
    else                          low_run <= low_run + CNT_W'(1);
  end

  // R2
  reset_high_chk: assert property (@(posedge clk) rst |=> sync_o);

  // R3
  low_len_chk: assert property (@(posedge clk) disable iff (rst || sel_chg)
    !sync_o |-> (low_run < lead_chk));

  // R3
  no_low_glitch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |=> !sync_o);

  // R4
  no_high_glitch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |=> sync_o);
endmodule

bind csync_gen csync_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel_a  (sel_a),
  .sel_c  (sel_c),
  .sync_o (sync_o)
);

// File: tb/csync_gen_bench.sv
`timescale 1ns/1ps
module csync_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_a = '0;
  logic [1:0] sel_c = '0;
  logic       sync_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  v;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  csync_gen u_csync_gen (
    .clk    (clk),
    .rst    (rst),
    .sel_a  (sel_a),
    .sel_c  (sel_c),
    .sync_o (sync_o)
  );

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sync_o !== it.v) begin
        errors++;
        $display("FAIL %s: sync_o=%b expected %b", it.tag, sync_o, it.v);
      end
    end
  end

  function automatic int bench_lcm(int x, int y);
    int r;
    r = x;
    while ((r % y) != 0) r += x;
    return r;
  endfunction

  // R1 encodings
  function automatic int a_div(int s);
    case (s) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
  endfunction
  function automatic int c_div(int s);
    case (s) 0: return 2; 1: return 4; 2: return 6; default: return 8; endcase
  endfunction

  task automatic push(logic v, string tag);
    item_t it;
    it.v = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_case(int sa, int sc, string ctag, int ncyc);
    int da, dc, m, p;
    logic e;
    da = a_div(sa);
    dc = c_div(sc);
    m  = (da < dc) ? da : dc;
    p  = (da == dc) ? 2 * da : bench_lcm(da, dc);
    @(negedge clk);
    sel_a = 2'(sa);
    sel_c = 2'(sc);
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 push(1'b1, {ctag, "/R2 reset high"});
    end
    @(negedge clk);
    rst = 1'b0;
    for (int n = 1; n <= ncyc; n++) begin
      @(posedge clk);
      #1;
      e = ((n % p) < (p - m));
      if (da == dc)   push(e, {ctag, "/R5 equal"});
      else if (!e)    push(e, {ctag, "/R3 low window"});
      else            push(e, {ctag, "/R4 high"});
    end
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run_case(0, 1, "R5", 40);   // 4:4
    run_case(2, 3, "R5", 50);   // 8:8
    run_case(0, 0, "R6", 40);   // 4:2  2:1
    run_case(1, 0, "R6", 40);   // 6:2  3:1
    run_case(2, 0, "R6", 40);   // 8:2  4:1
    run_case(3, 0, "R6", 50);   // 12:2 6:1
    run_case(1, 1, "R6", 50);   // 6:4  3:2
    run_case(2, 2, "R6", 80);   // 8:6  4:3
    run_case(3, 3, "R1", 80);   // 12:8 3:2
    run_case(3, 2, "R1", 50);   // 12:6 2:1
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule